// File: doc/BRIEF.md
# Signed Divide Unit with Register Interface

This block is a signed integer divider that sits on a simple word-addressed register bus. Software loads a divisor and then writes a dividend. The dividend write itself launches the operation. A write to the single-word dividend address starts a 32-by-32 divide. A write to the low result word starts a 64-by-32 divide, and that divide takes the previously written high result word as the upper half of the dividend.

The engine is iterative and retires one quotient bit per clock. When it finishes, the quotient lands in the low result word and the remainder in the high result word. A zero divisor raises a sticky error flag, and so does a wide quotient that cannot be held in a signed 32-bit word. On an error, both result words saturate to the largest positive value. Software can clear the flag but never set it. With its enable set, the flag raises an interrupt line. Reads of result addresses stall while a divide is in flight. A new dividend write during a divide abandons the old one and restarts with the new operands.

Top module: `sdiv_mmio`

## Requirements
- R1: Writing address 1 starts a signed 32-by-32 divide of the written value by the divisor (address 0). The quotient, truncated toward zero, goes to the low result word (address 5). The remainder, with the sign of the dividend, goes to the high result word (address 4).
- R2: Writing address 5 starts a signed 64-by-32 divide. The dividend is {high result word (address 4), written value}. Results land as in R1.
- R3: A zero divisor, in either width, sets the error flag (control word bit 16, address 2). Both result words then read 0x7FFFFFFF.
- R4: A 64-by-32 quotient outside the range -2^31 to 2^31-1 sets the error flag and saturates both result words to 0x7FFFFFFF. A quotient of exactly -2^31 is valid.
- R5: A 32-by-32 divide of 0x80000000 by -1 gives quotient 0x80000000 and remainder 0, and does not set the error flag.
- R6: Writing the control word with bit 16 = 0 clears the error flag. Writing bit 16 = 1 leaves the flag as it was, so software can never set it.
- R7: The irq output is high exactly when the error flag and the interrupt enable (control word bit 1) are both set.
- R8: Reads of addresses 1 and 7 return the quotient word. A read of address 6 returns the remainder word.
- R9: busy rises on the cycle after a start write. It stays high for 33 cycles for a 32-by-32 divide and 65 cycles for a 64-by-32 divide. While busy is high, bus_wait is asserted for reads of addresses 1, 4, 5, 6 and 7, and is not asserted for reads of addresses 0 and 2.
- R10: A start write while busy is high discards the running divide. Only the new divide's result is stored, and busy then lasts its full length counted from the new start.
- R11: After reset, the result words, divisor, control word, busy and irq all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| bus_wait | output | 1 | Read stall while a result is pending |
| busy | output | 1 | Divide in progress or result being stored |
| irq | output | 1 | Error interrupt request |

## Verification
The assertions assume that bus_wr is a single-cycle strobe, that only one register is written per cycle, and that a reset is applied before the first access. The stimulus drives every bus signal half a period away from the sampling edge. It never holds bus_wr high for more than one rising edge, and it reads results only after busy has fallen, except in the deliberate stall probe. The 64-by-32 operands are chosen so that the bench's own 64-bit reference never meets the one case that overflows its arithmetic, the most negative dividend divided by minus one.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = $clog2(2 * DATA_W);

  typedef logic [DATA_W-1:0]   word_t;
  typedef logic [2*DATA_W-1:0] dword_t;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_DIVISOR = 3'd0;
  localparam logic [ADDR_W-1:0] A_DVD_SGL = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_SPARE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RES_HI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RES_LO  = 3'd5;
  localparam logic [ADDR_W-1:0] A_REM_ALT = 3'd6;
  localparam logic [ADDR_W-1:0] A_QUO_ALT = 3'd7;

  localparam int ERR_BIT = 16;
  localparam int IEN_BIT = 1;

  localparam word_t SAT_WORD = {1'b0, {(DATA_W-1){1'b1}}};

  // unsigned magnitude of a two's complement word
  function automatic word_t mag_word(input word_t v);
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  // negate a magnitude when the sign says so
  function automatic word_t signed_word(input word_t m, input logic neg);
    return neg ? (~m + 1'b1) : m;
  endfunction

  // does a quotient magnitude fit a signed word of the given sign
  function automatic logic quo_fits(input dword_t qmag, input logic neg);
    dword_t lim;
    lim = dword_t'(1) << (DATA_W - 1);
    return neg ? (qmag <= lim) : (qmag < lim);
  endfunction

  // true for the addresses whose read value depends on a pending divide
  function automatic logic is_result_addr(input logic [ADDR_W-1:0] a);
    return (a == A_DVD_SGL) || (a == A_RES_HI) || (a == A_RES_LO) ||
           (a == A_REM_ALT) || (a == A_QUO_ALT);
  endfunction
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core
  import sdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   wide,
  input  dword_t dvd,
  input  word_t  dvs,
  output logic   busy,
  output logic   done,
  output logic   err,
  output word_t  quo,
  output word_t  rem
);
  localparam logic [CNT_W-1:0] LAST_WIDE = CNT_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SGL  = CNT_W'(DATA_W - 1);

  logic             busy_r, done_r, wide_r, q_neg_r, r_neg_r, zero_r;
  logic [CNT_W-1:0] cnt_r;
  dword_t           sh_r;
  word_t            part_r, dvs_mag_r;

  // start-time operand preparation
  logic  dvd_neg;
  dword_t sh_load;
  always_comb begin
    dvd_neg = wide ? dvd[2*DATA_W-1] : dvd[DATA_W-1];
    if (wide)
      sh_load = dvd[2*DATA_W-1] ? (~dvd + 1'b1) : dvd;
    else
      sh_load = {mag_word(dvd[DATA_W-1:0]), {DATA_W{1'b0}}};
  end

  // one restoring step
  logic [DATA_W:0] trial, diff;
  logic            take;
  word_t           part_nx;
  dword_t          sh_nx;
  always_comb begin
    trial   = {part_r, sh_r[2*DATA_W-1]};
    diff    = trial - {1'b0, dvs_mag_r};
    take    = trial >= {1'b0, dvs_mag_r};
    part_nx = take ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
    sh_nx   = {sh_r[2*DATA_W-2:0], take};
  end

  logic [CNT_W-1:0] last_cnt;
  assign last_cnt = wide_r ? LAST_WIDE : LAST_SGL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r    <= 1'b0;
      done_r    <= 1'b0;
      wide_r    <= 1'b0;
      q_neg_r   <= 1'b0;
      r_neg_r   <= 1'b0;
      zero_r    <= 1'b0;
      cnt_r     <= '0;
      sh_r      <= '0;
      part_r    <= '0;
      dvs_mag_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        busy_r    <= 1'b1;
        wide_r    <= wide;
        r_neg_r   <= dvd_neg;
        q_neg_r   <= dvd_neg ^ dvs[DATA_W-1];
        zero_r    <= (dvs == '0);
        dvs_mag_r <= mag_word(dvs);
        sh_r      <= sh_load;
        part_r    <= '0;
        cnt_r     <= '0;
      end else if (busy_r) begin
        sh_r   <= sh_nx;
        part_r <= part_nx;
        cnt_r  <= cnt_r + 1'b1;
        if (cnt_r == last_cnt) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quo  = signed_word(sh_r[DATA_W-1:0], q_neg_r);
  assign rem  = signed_word(part_r, r_neg_r);
  assign err  = zero_r | (wide_r & ~quo_fits(sh_r, q_neg_r));
endmodule

// File: rtl/sdiv_flag.sv
module sdiv_flag
  import sdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_err,
  input  logic ctrl_wr,
  input  logic wr_err,
  input  logic wr_ien,
  output logic err_flag,
  output logic ien,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      ien      <= 1'b0;
    end else begin
      if (set_err)
        err_flag <= 1'b1;
      else if (ctrl_wr)
        err_flag <= err_flag & wr_err;
      if (ctrl_wr)
        ien <= wr_ien;
    end
  end

  assign irq = err_flag & ien;
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
  import sdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              busy,
  output logic              irq
);
  word_t  divisor_r, hi_r, lo_r;
  logic   core_busy, core_done, core_err;
  word_t  core_quo, core_rem;
  logic   ovf_flag, ien;

  // named internal events
  logic start_sgl, start_wide, start, res_load, res_err, ctrl_wr;
  assign start_sgl  = bus_wr && (bus_addr == A_DVD_SGL);
  assign start_wide = bus_wr && (bus_addr == A_RES_LO);
  assign start      = start_sgl || start_wide;
  assign res_load   = core_done && !start;
  assign res_err    = core_err;
  assign ctrl_wr    = bus_wr && (bus_addr == A_CTRL);

  dword_t core_dvd;
  assign core_dvd = start_wide ? {hi_r, bus_wdata} : {{DATA_W{1'b0}}, bus_wdata};

  sdiv_core u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .wide  (start_wide),
    .dvd   (core_dvd),
    .dvs   (divisor_r),
    .busy  (core_busy),
    .done  (core_done),
    .err   (core_err),
    .quo   (core_quo),
    .rem   (core_rem)
  );

  sdiv_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_err  (res_load && res_err),
    .ctrl_wr  (ctrl_wr),
    .wr_err   (bus_wdata[ERR_BIT]),
    .wr_ien   (bus_wdata[IEN_BIT]),
    .err_flag (ovf_flag),
    .ien      (ien),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor_r <= '0;
      hi_r      <= '0;
      lo_r      <= '0;
    end else begin
      if (bus_wr && (bus_addr == A_DIVISOR))
        divisor_r <= bus_wdata;
      if (res_load)
        hi_r <= res_err ? SAT_WORD : core_rem;
      else if (bus_wr && (bus_addr == A_RES_HI))
        hi_r <= bus_wdata;
      if (res_load)
        lo_r <= res_err ? SAT_WORD : core_quo;
      else if (start_wide)
        lo_r <= bus_wdata;
    end
  end

  assign busy     = core_busy | core_done;
  assign bus_wait = bus_rd && busy && is_result_addr(bus_addr);

  word_t ctrl_view;
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[ERR_BIT] = ovf_flag;
    ctrl_view[IEN_BIT] = ien;
  end

  always_comb begin
    case (bus_addr)
      A_DIVISOR: bus_rdata = divisor_r;
      A_DVD_SGL: bus_rdata = lo_r;
      A_CTRL:    bus_rdata = ctrl_view;
      A_RES_HI:  bus_rdata = hi_r;
      A_RES_LO:  bus_rdata = lo_r;
      A_REM_ALT: bus_rdata = hi_r;
      A_QUO_ALT: bus_rdata = lo_r;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk
  import sdiv_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  busy,
  input logic  bus_wait,
  input logic  start,
  input logic  res_load,
  input logic  res_err,
  input logic  ovf,
  input logic  ctrl_wr,
  input word_t hi,
  input word_t lo
);
  // R3 R4
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && res_err) |=> (hi == SAT_WORD && lo == SAT_WORD));

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ovf) && ovf) |-> $past(res_load && res_err));

  // R6
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !(res_load && res_err) && !ovf) |=> !ovf);

  // R9
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> busy);

  // R10
  restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R9
  finish_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(res_load));
endmodule

bind sdiv_mmio sdiv_mmio_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .bus_wait (bus_wait),
  .start    (start),
  .res_load (res_load),
  .res_err  (res_err),
  .ovf      (ovf_flag),
  .ctrl_wr  (ctrl_wr),
  .hi       (hi_r),
  .lo       (lo_r)
);

// File: tb/sdiv_mmio_test.sv
module sdiv_mmio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait, busy, irq;

  always #5 clk = ~clk;

  sdiv_mmio uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wait(bus_wait), .busy(busy), .irq(irq)
  );

  typedef struct {
    logic [31:0] q;
    logic [31:0] r;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   mon_req = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    while (bus_wait) begin
      @(negedge clk);
      #1;
    end
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // reference model: 64-bit signed arithmetic, truncating division
  function automatic exp_t model(input bit wide, input longint a, input int b, input string tag);
    exp_t   e;
    longint lb, qq, rr;
    lb = b;
    e.tag = tag;
    if (b == 0) begin
      e.ovf = 1'b1; e.q = 32'h7fffffff; e.r = 32'h7fffffff;
    end else begin
      qq = a / lb;
      rr = a % lb;
      if (wide && (qq > 64'sd2147483647 || qq < -64'sd2147483648)) begin
        e.ovf = 1'b1; e.q = 32'h7fffffff; e.r = 32'h7fffffff;
      end else begin
        e.ovf = 1'b0; e.q = qq[31:0]; e.r = rr[31:0];
      end
    end
    return e;
  endfunction

  // driver: load operands, start, push expectation, time busy, hand to monitor
  task automatic run_op(input bit wide, input longint a, input int b, input string tag, input bit probe);
    int n;
    logic [31:0] a_lo;
    a_lo = a[31:0];
    bus_write(3'd0, b);
    if (wide) begin
      bus_write(3'd4, a[63:32]);
      bus_write(3'd5, a_lo);
      exp_q.push_back(model(1'b1, a, b, tag));
    end else begin
      bus_write(3'd1, a_lo);
      exp_q.push_back(model(1'b0, longint'($signed(a_lo)), b, tag));
    end
    if (probe) begin
      // R9: stall only result reads while busy
      bus_rd = 1'b1; bus_addr = 3'd0; #1;
      check(bus_wait == 1'b0, "R9 no stall divisor", {31'b0, bus_wait}, 32'd0);
      bus_addr = 3'd2; #1;
      check(bus_wait == 1'b0, "R9 no stall ctrl", {31'b0, bus_wait}, 32'd0);
      bus_addr = 3'd5; #1;
      check(bus_wait == 1'b1, "R9 stall result", {31'b0, bus_wait}, 32'd1);
      bus_rd = 1'b0; #1;
    end
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == (wide ? 65 : 33), {"R9 busy length ", tag}, n, wide ? 65 : 33);
    mon_req = 1'b1;
    wait (mon_req == 1'b0);
  endtask

  // monitor: pop expectation, read results through the bus, compare
  initial begin
    exp_t e;
    logic [31:0] v;
    forever begin
      wait (mon_req == 1'b1);
      e = exp_q.pop_front();
      bus_read(3'd5, v);
      check(v === e.q, {e.tag, " quotient"}, v, e.q);
      bus_read(3'd4, v);
      check(v === e.r, {e.tag, " remainder"}, v, e.r);
      bus_read(3'd2, v);
      check(v[16] === e.ovf, {e.tag, " error flag R3"}, {31'b0, v[16]}, {31'b0, e.ovf});
      bus_read(3'd1, v);
      check(v === e.q, "R8 quotient alias 1", v, e.q);
      bus_read(3'd7, v);
      check(v === e.q, "R8 quotient alias 7", v, e.q);
      bus_read(3'd6, v);
      check(v === e.r, "R8 remainder alias 6", v, e.r);
      mon_req = 1'b0;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(busy == 1'b0, "R11 busy", {31'b0, busy}, 0);
    check(irq == 1'b0, "R11 irq", {31'b0, irq}, 0);
    bus_read(3'd2, v); check(v == 0, "R11 ctrl", v, 0);
    bus_read(3'd4, v); check(v == 0, "R11 high result", v, 0);
    bus_read(3'd5, v); check(v == 0, "R11 low result", v, 0);
    bus_read(3'd0, v); check(v == 0, "R11 divisor", v, 0);

    // R1 sign combinations
    run_op(1'b0, 100, 7, "R1 pos/pos", 1'b1);
    run_op(1'b0, -100, 7, "R1 neg/pos", 1'b0);
    run_op(1'b0, 100, -7, "R1 pos/neg", 1'b0);
    run_op(1'b0, -100, -7, "R1 neg/neg", 1'b0);
    run_op(1'b0, 64'h7fffffff, 1, "R1 max/1", 1'b0);
    run_op(1'b0, 3, 10, "R1 small", 1'b0);
    // R5 wrap case
    run_op(1'b0, 64'hffffffff80000000, -1, "R5 min/-1", 1'b0);
    // R3 zero divisor single
    run_op(1'b0, 5, 0, "R3 zero sgl", 1'b0);
    // R6 writing 1 keeps the flag, writing 0 clears it
    bus_write(3'd2, 32'h0001_0000);
    bus_read(3'd2, v); check(v[16] == 1'b1, "R6 keep on 1", {31'b0, v[16]}, 1);
    bus_write(3'd2, 32'h0);
    bus_read(3'd2, v); check(v[16] == 1'b0, "R6 clear on 0", {31'b0, v[16]}, 0);
    bus_write(3'd2, 32'h0001_0000);
    bus_read(3'd2, v); check(v[16] == 1'b0, "R6 no software set", {31'b0, v[16]}, 0);

    // R2 wide divides
    run_op(1'b1, 64'sh1_0000_0000, 4, "R2 2^32/4", 1'b1);
    run_op(1'b1, -64'sd1099511627773, 1000, "R2 neg wide", 1'b0);
    run_op(1'b1, 64'sh12_3456_789a, -77777, "R2 neg divisor", 1'b0);
    // R4 quotient range boundaries
    run_op(1'b1, -64'sh1_0000_0000, 2, "R4 exact -2^31", 1'b0);
    run_op(1'b1, 64'sh1_0000_0000, 2, "R4 +2^31 overflow", 1'b0);
    bus_write(3'd2, 32'h0);
    run_op(1'b1, 64'sh1_0000_0000, 0, "R3 zero wide", 1'b0);

    // R7 interrupt follows flag and enable
    check(irq == 1'b0, "R7 irq disabled", {31'b0, irq}, 0);
    bus_write(3'd2, 32'h0001_0002);
    #1 check(irq == 1'b1, "R7 irq enabled", {31'b0, irq}, 1);
    bus_write(3'd2, 32'h0000_0002);
    #1 check(irq == 1'b0, "R7 irq after clear", {31'b0, irq}, 0);
    bus_read(3'd2, v); check(v == 32'h2, "R11 ctrl layout", v, 32'h2);
    bus_write(3'd2, 32'h0);

    // R10 restart: abandon a wide divide midway
    bus_write(3'd0, 3);
    bus_write(3'd4, 32'h0000_0005);
    bus_write(3'd5, 32'h1234_5678);
    repeat (10) @(negedge clk);
    run_op(1'b0, 77, -5, "R10 restart", 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule